// File: doc/BRIEF.md
# ADC Clock Prescaler and Sample-Window Generator

This block takes the fast peripheral clock and produces the timing of an ADC conversion: the clock for the conversion core and the sample-and-hold window. Everything runs on one clock. The divided ADC clock is therefore a one-cycle clock-enable strobe, `adc_clk_en`, and no derived or gated clock is created.

The clock chain has two stages in series:

- **Stage 1** is controlled by a 4-bit prescale code. Code 0 passes every peripheral cycle through. A nonzero code n divides by 2n, so the ratios run from /2 down to /30.
- **Stage 2** is an optional halving stage, selected by one bit.

A module enable gates the whole chain. Any change of the divider settings restarts both stages from zero. This keeps short or partial periods off the output.

A start request opens a sample window. The window stays open for (acquisition code + 1) ADC-clock enables. On the next ADC-clock enable after the window closes, the block issues a one-cycle conversion-start strobe. The acquisition code therefore stretches only the sampling phase. A busy flag covers the whole sequence, and start requests that arrive while busy are dropped.

Top module: `adc_clk_window_gen`

## Requirements
- R1: With prescale code 0 and the halving bit 0, `adc_clk_en` is high in every cycle while enabled, except the cycle in which a setting changes.
- R2: With a nonzero prescale code n and the halving bit 0, `adc_clk_en` pulses for one cycle every 2n cycles.
- R3: With the halving bit 1, the period produced by the prescale code is doubled (code 0 gives a period of 2). Two consecutive cycles never both carry `adc_clk_en`.
- R4: In the cycle where `prescale` or `div2_sel` differs from its value in the previous cycle, `adc_clk_en` is low and both stages restart. The first pulse then comes exactly one full period P after that cycle.
- R5: While `mod_en` is low, `adc_clk_en` is low and start requests are ignored. One cycle after `mod_en` goes low, `sample_pulse`, `busy` and `conv_start` are low.
- R6: An accepted request raises `sample_pulse` in the next cycle. `sample_pulse` stays high across exactly `acq_len` + 1 cycles that carry `adc_clk_en`, the last high cycle being one of them.
- R7: After `sample_pulse` falls, `conv_start` is high for exactly one cycle, in the cycle after the first cycle that carries `adc_clk_en`.
- R8: `busy` is high from the cycle after acceptance up to and including the cycle before `conv_start`. A `soc_req` while busy starts no new window.
- R9: After reset, all outputs are low. When `mod_en` is first raised with all settings at zero, `adc_clk_en` is high in that same cycle, and a window with code 0 spans one enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mod_en | input | 1 | Enables the clock chain and the window logic |
| prescale | input | 4 | Stage-1 code: 0 = x1, n = divide by 2n |
| div2_sel | input | 1 | 1 = extra divide-by-two in stage 2 |
| acq_len | input | 4 | Sample window length minus one, in ADC-clock enables |
| soc_req | input | 1 | Start-of-conversion request |
| adc_clk_en | output | 1 | One-cycle ADC clock enable strobe |
| sample_pulse | output | 1 | Sample-and-hold window |
| conv_start | output | 1 | One-cycle conversion-start strobe |
| busy | output | 1 | Window or conversion-start pending |

## Verification
`adc_clk_en` is combinational on the divider state. It is therefore checked in the same cycle as the settings that produce it: a period-P configuration pulses at cycle offsets P, 2P and 3P after the change cycle. `sample_pulse` and `busy` are registered and appear one cycle after the request is accepted. `conv_start` appears one cycle after the first enable that follows the window. The bench drives inputs at the falling edge and samples one nanosecond later. Each sample therefore belongs to exactly one cycle, and the bench compares enable counts and offsets, not absolute times, so the phase of the divider never matters.

// File: rtl/adc_clk_pkg.sv
package adc_clk_pkg;

  typedef enum logic [1:0] {
    WIN_IDLE   = 2'd0,
    WIN_SAMPLE = 2'd1,
    WIN_WAIT   = 2'd2
  } win_state_t;

endpackage

// File: rtl/adc_pre_div.sv
// Stage 1: code 0 = every cycle, code n = one strobe every 2n cycles.
module adc_pre_div #(
  parameter int PS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic [PS_W-1:0] prescale,
  output logic            tick_o
);

  localparam int CNT_W = PS_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] wrap_val;
  logic             bypass;
  logic             at_wrap;

  always_comb begin
    bypass   = (prescale == '0);
    wrap_val = {prescale, 1'b0} - CNT_W'(1);
    at_wrap  = (cnt_q == wrap_val);
    tick_o   = run && !restart && (bypass || at_wrap);
    if (!run || restart || bypass || at_wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/adc_half_div.sv
// Stage 2: passes stage-1 strobes, or every second one when halving.
module adc_half_div (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic div2,
  input  logic tick_i,
  output logic tick_o
);

  logic phase_q;
  logic phase_d;

  always_comb begin
    if (!run || restart) begin
      phase_d = 1'b0;
    end else if (tick_i && div2) begin
      phase_d = !phase_q;
    end else begin
      phase_d = phase_q;
    end
    tick_o = tick_i && (!div2 || phase_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/adc_win_fsm.sv
// Sample window of (acq_len + 1) ADC enables, then a conversion-start strobe
// on the following enable.
module adc_win_fsm
  import adc_clk_pkg::*;
#(
  parameter int ACQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             soc_req,
  input  logic             tick,
  input  logic [ACQ_W-1:0] acq_len,
  output logic             sample_o,
  output logic             conv_o,
  output logic             busy_o
);

  win_state_t       state_q, state_d;
  logic [ACQ_W-1:0] cnt_q, cnt_d;
  logic             sample_q, sample_d;
  logic             conv_q, conv_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sample_d = sample_q;
    conv_d   = 1'b0;
    if (!run) begin
      state_d  = WIN_IDLE;
      cnt_d    = '0;
      sample_d = 1'b0;
    end else begin
      case (state_q)
        WIN_IDLE: begin
          if (soc_req) begin
            state_d  = WIN_SAMPLE;
            cnt_d    = '0;
            sample_d = 1'b1;
          end
        end
        WIN_SAMPLE: begin
          if (tick) begin
            if (cnt_q >= acq_len) begin
              state_d  = WIN_WAIT;
              sample_d = 1'b0;
            end else begin
              cnt_d = cnt_q + ACQ_W'(1);
            end
          end
        end
        WIN_WAIT: begin
          if (tick) begin
            state_d = WIN_IDLE;
            conv_d  = 1'b1;
          end
        end
        default: begin
          state_d  = WIN_IDLE;
          sample_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WIN_IDLE;
      cnt_q    <= '0;
      sample_q <= 1'b0;
      conv_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      sample_q <= sample_d;
      conv_q   <= conv_d;
    end
  end

  assign sample_o = sample_q;
  assign conv_o   = conv_q;
  assign busy_o   = (state_q != WIN_IDLE);

endmodule

// File: rtl/adc_clk_window_gen.sv
module adc_clk_window_gen #(
  parameter int PS_W  = 4,
  parameter int ACQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_en,
  input  logic [PS_W-1:0]  prescale,
  input  logic             div2_sel,
  input  logic [ACQ_W-1:0] acq_len,
  input  logic             soc_req,
  output logic             adc_clk_en,
  output logic             sample_pulse,
  output logic             conv_start,
  output logic             busy
);

  localparam int CFG_W = PS_W + 1;

  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_now;
  logic             cfg_chg;
  logic             tick_s1;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  assign cfg_now = {prescale, div2_sel};
  assign cfg_chg = (cfg_now != cfg_q);

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_now;
    end
  end

  adc_pre_div #(.PS_W(PS_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .run      (mod_en),
    .restart  (cfg_chg),
    .prescale (prescale),
    .tick_o   (tick_s1)
  );

  adc_half_div u_half (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .run     (mod_en),
    .restart (cfg_chg),
    .div2    (div2_sel),
    .tick_i  (tick_s1),
    .tick_o  (adc_clk_en)
  );

  adc_win_fsm #(.ACQ_W(ACQ_W)) u_win (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .run      (mod_en),
    .soc_req  (soc_req),
    .tick     (adc_clk_en),
    .acq_len  (acq_len),
    .sample_o (sample_pulse),
    .conv_o   (conv_start),
    .busy_o   (busy)
  );

endmodule

// File: rtl/adc_clk_window_chk.sv
module adc_clk_window_chk (
  input logic clk,
  input logic rst_n,
  input logic mod_en,
  input logic div2_sel,
  input logic adc_clk_en,
  input logic sample_pulse,
  input logic conv_start,
  input logic busy
);

  // R5
  dis_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |-> !adc_clk_en);

  // R5
  dis_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> (!sample_pulse && !busy && !conv_start));

  // R8
  sample_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pulse |-> busy);

  // R7
  conv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R7
  conv_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !sample_pulse);

  // R6
  close_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sample_pulse) && $past(mod_en)) |-> $past(adc_clk_en));

  // R3
  div2_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div2_sel && adc_clk_en) |=> !adc_clk_en);

endmodule

bind adc_clk_window_gen adc_clk_window_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mod_en       (mod_en),
  .div2_sel     (div2_sel),
  .adc_clk_en   (adc_clk_en),
  .sample_pulse (sample_pulse),
  .conv_start   (conv_start),
  .busy         (busy)
);

// File: tb/adc_clk_window_gen_test.sv
module adc_clk_window_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mod_en = 1'b0;
  logic [3:0] prescale = 4'd0;
  logic       div2_sel = 1'b0;
  logic [3:0] acq_len = 4'd0;
  logic       soc_req = 1'b0;
  logic       adc_clk_en, sample_pulse, conv_start, busy;

  logic s_en, s_smp, s_conv, s_busy;
  int   checks = 0;
  int   errors = 0;

  always #4 clk = ~clk;

  adc_clk_window_gen uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mod_en       (mod_en),
    .prescale     (prescale),
    .div2_sel     (div2_sel),
    .acq_len      (acq_len),
    .soc_req      (soc_req),
    .adc_clk_en   (adc_clk_en),
    .sample_pulse (sample_pulse),
    .conv_start   (conv_start),
    .busy         (busy)
  );

  // Inputs are set at a falling edge; sample 1 ns later, then move to the next falling edge.
  task automatic step();
    #1;
    s_en   = adc_clk_en;
    s_smp  = sample_pulse;
    s_conv = conv_start;
    s_busy = busy;
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_div(input int ps, input int d);
    int p     = ((ps == 0) ? 1 : 2 * ps) * (d + 1);
    int first = -1;
    int bad   = 0;
    string tag = (d == 1) ? "R3" : ((ps == 0) ? "R1" : "R2");
    div2_sel = d[0];
    prescale = 4'(ps ^ 1);
    step();
    prescale = 4'(ps);
    for (int k = 0; k <= 3 * p; k++) begin
      step();
      if (s_en && first < 0) first = k;
      if (s_en != (k > 0 && (k % p) == 0)) bad++;
    end
    chk(first == p, "R4", first, p, $sformatf("first strobe after change ps=%0d d=%0d", ps, d));
    chk(bad == 0, tag, bad, 0, $sformatf("strobe pattern mismatches ps=%0d d=%0d", ps, d));
  endtask

  task automatic run_window(input int acq);
    int  ens = 0;
    int  n = 0;
    int  guard = 0;
    bit  last = 1'b0;
    bit  busy_ok = 1'b1;
    bit  quiet = 1'b1;
    acq_len = 4'(acq);
    soc_req = 1'b1;
    step();
    chk(!s_busy && !s_smp, "R8", s_busy, 0, "busy before accept");
    soc_req = 1'b0;
    step();
    chk(s_smp, "R6", s_smp, 1, "window opens one cycle after accept");
    while (s_smp && guard < 2000) begin
      if (!s_busy) busy_ok = 1'b0;
      if (s_en) ens++;
      last = s_en;
      soc_req = (n == 0);
      step();
      n++;
      guard++;
    end
    soc_req = 1'b0;
    chk(ens == acq + 1, "R6", ens, acq + 1, $sformatf("enables inside window acq=%0d", acq));
    chk(last, "R6", last, 1, "window closes on an enable cycle");
    guard = 0;
    while (!s_en && guard < 2000) begin
      if (!s_busy || s_conv) busy_ok = 1'b0;
      step();
      guard++;
    end
    if (!s_busy || s_conv) busy_ok = 1'b0;
    chk(busy_ok, "R8", busy_ok, 1, "busy held through window");
    step();
    chk(s_conv, "R7", s_conv, 1, "conversion start after first post-window enable");
    for (int i = 0; i < 3; i++) begin
      step();
      if (s_conv || s_smp || s_busy) quiet = 1'b0;
    end
    chk(quiet, "R8", quiet, 1, "request during busy ignored");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    step();
    rst_n = 1'b1;
    step();
    step();
    step();
    chk({s_en, s_smp, s_conv, s_busy} == 4'b0, "R9", {s_en, s_smp, s_conv, s_busy}, 0, "outputs after reset");
    mod_en = 1'b1;
    step();
    chk(s_en, "R9", s_en, 1, "first enabled cycle at x1");
    run_window(0);

    for (int ps = 0; ps < 16; ps++) begin
      for (int d = 0; d < 2; d++) begin
        run_div(ps, d);
      end
    end

    prescale = 4'd0;
    div2_sel = 1'b0;
    step();
    for (int a = 0; a < 16; a++) run_window(a);
    prescale = 4'd2;
    div2_sel = 1'b1;
    step();
    run_window(0);
    run_window(5);
    run_window(15);
    prescale = 4'd3;
    div2_sel = 1'b0;
    step();
    run_window(3);

    // R5: disable in the middle of a window
    acq_len = 4'd15;
    soc_req = 1'b1;
    step();
    soc_req = 1'b0;
    step();
    step();
    mod_en = 1'b0;
    step();
    chk(!s_en, "R5", s_en, 0, "no enable while disabled");
    step();
    chk(!s_smp && !s_busy, "R5", {s_smp, s_busy}, 0, "window dropped on disable");
    begin
      int hits = 0;
      soc_req = 1'b1;
      for (int i = 0; i < 20; i++) begin
        step();
        if (s_en || s_smp || s_conv || s_busy) hits++;
      end
      chk(hits == 0, "R5", hits, 0, "requests ignored while disabled");
    end
    soc_req = 1'b0;
    mod_en = 1'b1;
    step();
    step();
    chk(!s_smp && !s_busy, "R5", {s_smp, s_busy}, 0, "idle after re-enable");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule